// File: doc/BRIEF.md
# Event Time-Stamp Latch Array

This block holds one small code memory per pixel of an imaging array and records, for every pixel, when a bright object first crossed it during a short exposure. A shared counter steps through one full turn of Gray codes, one per clock, while an acquisition runs. Each pixel has a digital detect input, which stands in for its photodiode and threshold comparator. When that input goes from low to high during the acquisition, the pixel stores the counter's current code. Later edges on the same pixel leave the stored code alone until the array is preset again.

The array is used in three steps. First, a preset writes a chosen default code into every cell, so that pixels that never fire can be recognised. Second, an acquisition is started, and the counter runs for 2**CODE_W clocks and then stops. Third, pixels are read one at a time. The read port returns the raw stored code, its binary count and a grey level that is brighter for earlier events. The elapsed time of an event is the binary count divided by the clock frequency. A read/write-enable input holds every detect input low while it is high, so no capture can happen then.

Top module: `event_stamp_array`

## Requirements
- R1: After reset every cell holds code 0 and is marked as not fired, acq_busy_o is 0 and stamp_o is 0.
- R2: A one-cycle init_i pulse while no acquisition runs writes dflt_i into every cell and clears every fired mark.
- R3: An acq_start_i pulse while idle raises acq_busy_o on the next clock for exactly 2**CODE_W cycles. During those cycles stamp_o shows the Gray code of 0, 1, 2 and so on up to 2**CODE_W-1, changing once per clock, where Gray(b) = b XOR (b >> 1).
- R4: If a pixel's detect input is low at one rising clock edge and high at the next while acq_busy_o is 1, the cell stores the stamp_o value from just before that second edge and is marked as fired. A rise applied after the cycle where stamp_o shows Gray(k) stores Gray(k).
- R5: Once a cell is marked as fired, further rising edges on its detect input change nothing, in this acquisition and in later ones, until the next preset.
- R6: While rw_en_i is high, detect inputs are treated as low, so rises during that time store nothing.
- R7: A detect input that is already high when the acquisition starts, or that rises after acq_busy_o has fallen, stores nothing.
- R8: The read port is registered. One clock after rd_addr_i is applied, rd_code_o carries that pixel's stored Gray code and rd_fired_o carries its fired mark.
- R9: rd_bin_o is the binary count of rd_code_o; for example, code 4'b1000 reads as 15.
- R10: For a fired pixel rd_grey_o = 2**CODE_W-1 - rd_bin_o, so the earliest event is the brightest. For a pixel that has not fired, rd_grey_o equals the stored code unchanged, which is the preset default.
- R11: init_i and acq_start_i pulses that arrive while acq_busy_o is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Presets all cells to dflt_i |
| dflt_i | input | 4 | Default code used by the preset |
| acq_start_i | input | 1 | Starts one acquisition turn |
| rw_en_i | input | 1 | Holds all detect inputs low while high |
| detect_i | input | 16 | Per-pixel event inputs |
| rd_addr_i | input | 4 | Pixel selected for readout |
| acq_busy_o | output | 1 | High while the shared counter runs |
| stamp_o | output | 4 | Shared Gray time stamp |
| rd_code_o | output | 4 | Stored Gray code of the selected pixel |
| rd_bin_o | output | 4 | Binary count of the stored code |
| rd_grey_o | output | 4 | Grey level of the selected pixel |
| rd_fired_o | output | 1 | Selected pixel has fired since the last preset |

## Verification
The bench drives all inputs on the falling edge. A capture lands in the cell on the rising edge after its detect input rises. acq_busy_o and the first stamp_o code appear on the edge after the start pulse, and each later stamp_o code appears one edge after the one before it. The bench therefore checks stamp_o at every falling edge of the turn against Gray(k). Read results are due one rising edge after the address is applied. The driver queues each expected read as it sets the address, and the monitor compares the outputs 1 ns after that rising edge. Expected cell contents come from the bench's own model of the detect patterns, the rw_en_i mask and the first-rise rule.

// File: rtl/esa_pkg.sv
`timescale 1ns/1ps
package esa_pkg;
  localparam int unsigned CODE_W = 4;

  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t bin_to_gray(code_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic code_t gray_to_bin(code_t g);
    code_t b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = int'(CODE_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/esa_stamp_counter.sv
`timescale 1ns/1ps
module esa_stamp_counter
  import esa_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output logic  busy_o,
  output code_t stamp_o
);
  code_t bin_q;
  logic  busy_q;

  // one turn, then hold the last count until the next start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bin_q  <= '0;
    end else if (busy_q) begin
      if (bin_q == '1) busy_q <= 1'b0;
      else             bin_q  <= bin_q + 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      bin_q  <= '0;
    end
  end

  assign busy_o  = busy_q;
  assign stamp_o = bin_to_gray(bin_q);

  // R3
  stamp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $countones(stamp_o ^ $past(stamp_o)) == 1);

  // R3
  stamp_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> stamp_o == '0);
endmodule

// File: rtl/esa_pixel_cell.sv
`timescale 1ns/1ps
module esa_pixel_cell
  import esa_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  code_t dflt_i,
  input  logic  arm_i,
  input  logic  det_i,
  input  code_t stamp_i,
  output code_t code_o,
  output logic  fired_o
);
  code_t code_q;
  logic  fired_q;
  logic  det_q;
  logic  take;

  assign take = arm_i & det_i & ~det_q & ~fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) det_q <= 1'b0;
    else         det_q <= det_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      fired_q <= 1'b0;
    end else if (clr_i) begin
      code_q  <= dflt_i;
      fired_q <= 1'b0;
    end else if (take) begin
      code_q  <= stamp_i;
      fired_q <= 1'b1;
    end
  end

  assign code_o  = code_q;
  assign fired_o = fired_q;

  // R5
  first_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_q && !clr_i |=> $stable(code_q));

  // R4
  armed_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !$rose(fired_q));
endmodule

// File: rtl/esa_readout.sv
`timescale 1ns/1ps
module esa_readout
  import esa_pkg::*;
#(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  code_t [NUM_PIX-1:0]    codes_i,
  input  logic  [NUM_PIX-1:0]    fired_i,
  output code_t                  code_o,
  output code_t                  bin_o,
  output code_t                  grey_o,
  output logic                   fired_o
);
  code_t code_q;
  logic  fired_q;
  code_t bin_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      fired_q <= 1'b0;
    end else begin
      code_q  <= codes_i[addr_i];
      fired_q <= fired_i[addr_i];
    end
  end

  // one converter after the mux
  assign bin_w   = gray_to_bin(code_q);
  assign code_o  = code_q;
  assign bin_o   = bin_w;
  assign fired_o = fired_q;
  assign grey_o  = fired_q ? ~bin_w : code_q;

  // R9
  bin_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_o ^ (bin_o >> 1)) == code_o);
endmodule

// File: rtl/event_stamp_array.sv
`timescale 1ns/1ps
module event_stamp_array
  import esa_pkg::*;
#(
  parameter int unsigned NUM_PIX = 16,
  localparam int unsigned ADDR_W = $clog2(NUM_PIX)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic [CODE_W-1:0]    dflt_i,
  input  logic                 acq_start_i,
  input  logic                 rw_en_i,
  input  logic [NUM_PIX-1:0]   detect_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic                 acq_busy_o,
  output logic [CODE_W-1:0]    stamp_o,
  output logic [CODE_W-1:0]    rd_code_o,
  output logic [CODE_W-1:0]    rd_bin_o,
  output logic [CODE_W-1:0]    rd_grey_o,
  output logic                 rd_fired_o
);
  logic                busy;
  code_t               stamp;
  logic                clr;
  logic [NUM_PIX-1:0]  det_mask;
  logic [NUM_PIX-1:0]  fired_vec;
  code_t [NUM_PIX-1:0] code_vec;

  assign clr      = init_i & ~busy;
  assign det_mask = detect_i & {NUM_PIX{~rw_en_i}};

  esa_stamp_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (acq_start_i),
    .busy_o  (busy),
    .stamp_o (stamp)
  );

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    esa_pixel_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .dflt_i  (dflt_i),
      .arm_i   (busy),
      .det_i   (det_mask[p]),
      .stamp_i (stamp),
      .code_o  (code_vec[p]),
      .fired_o (fired_vec[p])
    );
  end

  esa_readout #(.NUM_PIX(NUM_PIX), .ADDR_W(ADDR_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (rd_addr_i),
    .codes_i (code_vec),
    .fired_i (fired_vec),
    .code_o  (rd_code_o),
    .bin_o   (rd_bin_o),
    .grey_o  (rd_grey_o),
    .fired_o (rd_fired_o)
  );

  assign acq_busy_o = busy;
  assign stamp_o    = stamp;

  // R6
  rw_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_en_i |=> (fired_vec & ~$past(fired_vec)) == '0);

  // R11
  busy_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && init_i |=> (fired_vec & $past(fired_vec)) == $past(fired_vec));
endmodule

// File: tb/tb_event_stamp_array.sv
`timescale 1ns/1ps
module tb_event_stamp_array;
  localparam int NPIX = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0;
  logic [3:0]  dflt_i = '0;
  logic        acq_start_i = 1'b0;
  logic        rw_en_i = 1'b0;
  logic [15:0] detect_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic        acq_busy_o;
  logic [3:0]  stamp_o, rd_code_o, rd_bin_o, rd_grey_o;
  logic        rd_fired_o;

  event_stamp_array #(.NUM_PIX(NPIX)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .dflt_i(dflt_i),
    .acq_start_i(acq_start_i), .rw_en_i(rw_en_i), .detect_i(detect_i),
    .rd_addr_i(rd_addr_i), .acq_busy_o(acq_busy_o), .stamp_o(stamp_o),
    .rd_code_o(rd_code_o), .rd_bin_o(rd_bin_o), .rd_grey_o(rd_grey_o),
    .rd_fired_o(rd_fired_o)
  );

  always #2 clk_i = ~clk_i;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  typedef struct {
    int         addr;
    logic [3:0] code;
    logic [3:0] bin;
    logic [3:0] grey;
    logic       fired;
    string      req;
  } rd_item_t;

  rd_item_t   rd_q[$];
  logic [3:0] m_code [NPIX];
  logic       m_fired[NPIX];

  function automatic logic [3:0] tb_gray(int b);
    logic [3:0] v = 4'(b);
    return v ^ (v >> 1);
  endfunction

  function automatic logic [3:0] tb_bin(logic [3:0] g);
    logic [3:0] b;
    b[3] = g[3];
    b[2] = b[3] ^ g[2];
    b[1] = b[2] ^ g[1];
    b[0] = b[1] ^ g[0];
    return b;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: read results due 1 ns after the edge that latches the address
  always @(posedge clk_i) begin
    #1;
    if (rd_q.size() > 0) begin
      rd_item_t it;
      it = rd_q.pop_front();
      check($sformatf("%s R8 code px%0d", it.req, it.addr), int'(rd_code_o), int'(it.code));
      check($sformatf("%s R8 fired px%0d", it.req, it.addr), int'(rd_fired_o), int'(it.fired));
      check($sformatf("%s R9 bin px%0d", it.req, it.addr), int'(rd_bin_o), int'(it.bin));
      check($sformatf("%s R10 grey px%0d", it.req, it.addr), int'(rd_grey_o), int'(it.grey));
    end
  end

  // driver
  task automatic read_px(int a, string req);
    rd_item_t it;
    @(negedge clk_i);
    rd_addr_i = 4'(a);
    it.addr  = a;
    it.code  = m_code[a];
    it.fired = m_fired[a];
    it.bin   = tb_bin(m_code[a]);
    it.grey  = m_fired[a] ? 4'(15 - int'(it.bin)) : m_code[a];
    it.req   = req;
    rd_q.push_back(it);
  endtask

  task automatic read_all(string req);
    for (int p = 0; p < NPIX; p++) read_px(p, req);
    @(negedge clk_i);
  endtask

  task automatic do_init(logic [3:0] d);
    @(negedge clk_i);
    init_i = 1'b1;
    dflt_i = d;
    @(negedge clk_i);
    init_i = 1'b0;
    for (int p = 0; p < NPIX; p++) begin
      m_code[p]  = d;
      m_fired[p] = 1'b0;
    end
  endtask

  function automatic logic [15:0] pat(int s, int k);
    logic [15:0] v;
    for (int p = 0; p < NPIX; p++) begin
      case (s)
        0: case (p)
             3:  v[p] = 1'b1;
             5:  v[p] = (k >= 2 && k < 4) || k >= 7;
             14: v[p] = k >= 15;
             15: v[p] = k >= 16;
             default: v[p] = k >= p;
           endcase
        1: v[p] = k >= 1;
        default: v[p] = k >= 3;
      endcase
    end
    return v;
  endfunction

  function automatic logic rwp(int s);
    return s == 2;
  endfunction

  task automatic run_acq(int s);
    logic [15:0] prev_m, cur_m, rise;
    @(negedge clk_i);
    detect_i    = pat(s, -1);
    rw_en_i     = rwp(s);
    acq_start_i = 1'b1;
    @(negedge clk_i);
    acq_start_i = 1'b0;
    for (int k = 0; k < 16; k++) begin
      check($sformatf("R3 busy k=%0d", k), int'(acq_busy_o), 1);
      check($sformatf("R3 stamp k=%0d", k), int'(stamp_o), int'(tb_gray(k)));
      detect_i = pat(s, k);
      rw_en_i  = rwp(s);
      if (s == 0 && k == 4) acq_start_i = 1'b1;      // R11 restart ignored
      if (s == 0 && k == 5) acq_start_i = 1'b0;
      if (s == 0 && k == 8) begin init_i = 1'b1; dflt_i = 4'hA; end // R11
      if (s == 0 && k == 9) init_i = 1'b0;
      prev_m = pat(s, k - 1) & {16{~rwp(s)}};
      cur_m  = pat(s, k) & {16{~rwp(s)}};
      rise   = cur_m & ~prev_m;
      for (int p = 0; p < NPIX; p++)
        if (rise[p] && !m_fired[p]) begin
          m_code[p]  = tb_gray(k);
          m_fired[p] = 1'b1;
        end
      @(negedge clk_i);
    end
    check("R3 busy end", int'(acq_busy_o), 0);
    detect_i = pat(s, 16);   // R7 rise after the turn
    @(negedge clk_i);
    rw_en_i = 1'b0;
    @(negedge clk_i);
    detect_i = '0;
    @(negedge clk_i);
  endtask

  initial begin
    for (int p = 0; p < NPIX; p++) begin
      m_code[p]  = '0;
      m_fired[p] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 busy", int'(acq_busy_o), 0);
    check("R1 stamp", int'(stamp_o), 0);
    read_all("R1");

    do_init(4'h5);
    read_all("R2");

    run_acq(0);
    read_all("R4 R5 R7 R10 R11");

    run_acq(1);
    read_all("R5");

    do_init(4'h0);
    run_acq(2);
    read_all("R6");

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule